// File: doc/BRIEF.md
# Byte Access Unit for Word Memory

This unit lets a client read or write single bytes of an array that sits in a memory organised as 16-bit words. The client gives a request with four parts:

- an operation, either load or store;
- the array's base word address;
- a signed byte index;
- a store datum.

The unit works out which word holds the byte and which half of that word the byte lives in. It then drives a single-port memory that has one cycle of read latency.

A load returns the chosen byte right-justified, with zeros above it. A store is a read-modify-write: the target word is read, one half is replaced, and the word is written back. A negative index reaches bytes below the base.

One request is in flight at a time. `ready` shows that a new request can be taken, and `done` pulses for one cycle when an operation has finished.

Top module: `byteAccessUnit`

## Requirements
- R1: The word address driven to memory equals the base plus the byte index shifted right by one with sign extension (for example index -1 gives base-1 and index -128 gives base-64), taken modulo 2^16.
- R2: An index whose bit 0 is 0 selects the upper half (bits 15:8) of the word, and an index whose bit 0 is 1 selects the lower half (bits 7:0).
- R3: A load of an upper byte returns word bits 15:8 in `loadData` bits 7:0, with bits 15:8 of `loadData` zero.
- R4: A load of a lower byte returns the word ANDed with 0x00FF.
- R5: A store writes back the word with only the selected half replaced; the other half keeps the value that was read.
- R6: A store uses only bits 7:0 of `reqData`; bits 15:8 have no effect on memory.
- R7: A store issues exactly one read, then exactly one write to the same address two cycles later, with no other access in between. A load issues one read and no write. `memRe` and `memWe` are never high together.
- R8: `ready` is high only when the unit is idle, and a request is accepted only when `reqValid` and `ready` are both high; requests raised while busy are ignored. `done` is a single-cycle pulse that comes 3 cycles after acceptance for a load and 4 cycles after acceptance for a store. `loadData` holds the loaded byte while `done` is high.
- R9: During and after reset, `ready` is 1 and `done`, `memRe` and `memWe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 1 | 0 = load, 1 = store |
| reqBase | input | 16 | Array base word address |
| reqIndex | input | 16 | Signed byte index |
| reqData | input | 16 | Store datum; only bits 7:0 used |
| ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| loadData | output | 16 | Loaded byte, zero-extended |
| memAddr | output | 16 | Memory word address |
| memRe | output | 1 | Memory read strobe; data arrives next cycle |
| memWe | output | 1 | Memory write strobe; committed at this edge |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data |

## Verification
A wrong controller state shows within one cycle at the ports in one of three ways: a strobe in the wrong cycle, a missing or doubled `done`, or `ready` high while the unit is busy. Because of this, the latency of each operation and the spacing between its read and write are measured directly.

A wrong half-select or a wrong merge does not show as a strobe error. It shows as a wrong byte in `loadData` on the `done` cycle, or as a corrupted neighbour byte in the memory word after a store. Each store is therefore followed by inspecting the whole word, and the written byte is then read back through the unit.

Negative indexes, including odd ones, are exercised because a logical rather than arithmetic shift would send them to an address far from the base.

// File: rtl/bauPkg.sv
package bauPkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } opKind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_LATCH = 2'd2,
    ST_WRITE = 2'd3
  } bauState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;    // register address, half select and datum
    logic grabLoad;   // register extracted byte as load result
    logic grabMerge;  // register merged word for write-back
  } bauStrobes_t;

endpackage

// File: rtl/bauControl.sv
module bauControl
  import bauPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  opKind_t     reqOp,
  output bauStrobes_t strobes,
  output logic        ready,
  output logic        done,
  output logic        memRe,
  output logic        memWe
);

  bauState_t state, stateNext;
  opKind_t   opReg;
  logic      doneNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    ready     = 1'b0;
    memRe     = 1'b0;
    memWe     = 1'b0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ready = 1'b1;
        if (reqValid) begin
          strobes.takeReq = 1'b1;
          stateNext       = ST_READ;
        end
      end
      ST_READ: begin
        memRe     = 1'b1;
        stateNext = ST_LATCH;
      end
      ST_LATCH: begin
        if (opReg == OP_STORE) begin
          strobes.grabMerge = 1'b1;
          stateNext         = ST_WRITE;
        end else begin
          strobes.grabLoad = 1'b1;
          doneNext         = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      ST_WRITE: begin
        memWe     = 1'b1;
        doneNext  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= OP_LOAD;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      if (strobes.takeReq) opReg <= reqOp;
    end
  end

  // R7
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R7
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(memRe, 2));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> !ready);

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/bauDatapath.sv
module bauDatapath
  import bauPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bauStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqIndex,
  input  logic [WORD_W-1:0] reqData,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] loadData
);

  localparam int BYTE_W = WORD_W / 2;

  logic [ADDR_W-1:0] wordOffset;
  logic [ADDR_W-1:0] addrReg;
  logic              lowSel;
  logic [BYTE_W-1:0] byteReg;
  logic [WORD_W-1:0] resultReg;
  logic [WORD_W-1:0] mergeReg;
  logic [BYTE_W-1:0] pickedByte;
  logic [WORD_W-1:0] mergedWord;
  logic              unusedDatumHigh;

  // arithmetic half of the signed byte index
  assign wordOffset = ADDR_W'($signed(reqIndex) >>> 1);

  // upper datum bits play no part in a store
  assign unusedDatumHigh = ^reqData[WORD_W-1:BYTE_W];

  assign pickedByte = lowSel ? memRdata[BYTE_W-1:0] : memRdata[WORD_W-1:BYTE_W];
  assign mergedWord = lowSel ? {memRdata[WORD_W-1:BYTE_W], byteReg}
                             : {byteReg, memRdata[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      lowSel    <= 1'b0;
      byteReg   <= '0;
      resultReg <= '0;
      mergeReg  <= '0;
    end else begin
      if (strobes.takeReq) begin
        addrReg <= reqBase + wordOffset;
        lowSel  <= reqIndex[0];
        byteReg <= reqData[BYTE_W-1:0];
      end
      if (strobes.grabLoad)  resultReg <= {{(WORD_W-BYTE_W){1'b0}}, pickedByte};
      if (strobes.grabMerge) mergeReg  <= mergedWord;
    end
  end

  assign memAddr  = addrReg;
  assign memWdata = mergeReg;
  assign loadData = resultReg;

  // R1
  addr_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grabMerge |=> $stable(memAddr));

endmodule

// File: rtl/byteAccessUnit.sv
module byteAccessUnit
  import bauPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqOp,
  input  logic [15:0] reqBase,
  input  logic [15:0] reqIndex,
  input  logic [15:0] reqData,
  output logic        ready,
  output logic        done,
  output logic [15:0] loadData,
  output logic [15:0] memAddr,
  output logic        memRe,
  output logic        memWe,
  output logic [15:0] memWdata,
  input  logic [15:0] memRdata
);

  bauStrobes_t strobes;

  bauControl u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (opKind_t'(reqOp)),
    .strobes  (strobes),
    .ready    (ready),
    .done     (done),
    .memRe    (memRe),
    .memWe    (memWe)
  );

  bauDatapath #(
    .ADDR_W (16),
    .WORD_W (16)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqBase  (reqBase),
    .reqIndex (reqIndex),
    .reqData  (reqData),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .loadData (loadData)
  );

  // R5
  one_half_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWdata[15:8] == $past(memRdata[15:8]) ||
               memWdata[7:0]  == $past(memRdata[7:0])));

  // R7
  write_same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr == $past(memAddr, 2));

endmodule

// File: tb/byteAccessUnit_test.sv
module byteAccessUnit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {op, base, index, datum}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 16'h0040, 16'h0000, 16'h0000},
    {1'b0, 16'h0040, 16'h0001, 16'h0000},
    {1'b0, 16'h0040, 16'hFFFF, 16'h0000},
    {1'b0, 16'h0040, 16'hFFFE, 16'h0000},
    {1'b0, 16'h0010, 16'h0025, 16'h0000},
    {1'b1, 16'h0050, 16'h0004, 16'h005A},
    {1'b0, 16'h0050, 16'h0004, 16'h0000},
    {1'b1, 16'h0050, 16'h0005, 16'hBEC3},
    {1'b0, 16'h0050, 16'h0005, 16'h0000},
    {1'b0, 16'h0050, 16'h0004, 16'h0000},
    {1'b1, 16'h0080, 16'hFF81, 16'h0011},
    {1'b0, 16'h0080, 16'hFF80, 16'h0000},
    {1'b1, 16'h0000, 16'h0001, 16'hFF77}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqOp = 1'b0;
  logic [15:0] reqBase = '0;
  logic [15:0] reqIndex = '0;
  logic [15:0] reqData = '0;
  logic        ready, done, memRe, memWe;
  logic [15:0] loadData, memAddr, memWdata;
  logic [15:0] memRdata;

  logic [15:0] mem    [256];
  logic [15:0] shadow [256];

  int tests = 0;
  int fails = 0;
  int cycle = 0;
  int rdCnt = 0, wrCnt = 0, rdAt = 0, wrAt = 0;
  logic [15:0] rdAddr = '0, wrAddr = '0;

  byteAccessUnit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBase(reqBase), .reqIndex(reqIndex), .reqData(reqData),
    .ready(ready), .done(done), .loadData(loadData),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] patternOf(int i);
    return {8'(i * 7 + 8'h11), 8'(i ^ 8'hC6)};
  endfunction

  // memory model: one-cycle read latency, write at the strobe edge
  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= patternOf(i);
      memRdata <= '0;
    end else begin
      if (memWe) mem[memAddr[7:0]] <= memWdata;
      if (memRe) memRdata <= mem[memAddr[7:0]];
    end
  end

  always @(negedge clk) begin
    if (rstN && memRe) begin rdCnt++; rdAddr = memAddr; rdAt = cycle; end
    if (rstN && memWe) begin wrCnt++; wrAddr = memAddr; wrAt = cycle; end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] wordAddrOf(logic [15:0] base, logic [15:0] idx);
    return base + 16'($signed(idx) >>> 1);
  endfunction

  // called and returns at a negative edge
  task automatic runOp(input logic op, input logic [15:0] base,
                       input logic [15:0] idx, input logic [15:0] dat);
    logic [15:0] ea, oldW, expW, expLoad;
    int lat, r0, w0;
    ea   = wordAddrOf(base, idx);
    oldW = shadow[ea[7:0]];
    r0 = rdCnt; w0 = wrCnt;
    check(ready, "R8", "ready before request", 32'(ready), 32'd1);
    reqValid = 1'b1; reqOp = op; reqBase = base; reqIndex = idx; reqData = dat;
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) reqValid = 1'b0;
    end while (!done && lat < 20);
    check(lat == (op ? 4 : 3), "R8", "latency", 32'(lat), op ? 32'd4 : 32'd3);
    check(rdAddr == ea, "R1", "read address", 32'(rdAddr), 32'(ea));
    if (!op) begin
      // R2 bit 0 picks the half; R3 upper, R4 lower
      expLoad = idx[0] ? {8'h00, oldW[7:0]} : {8'h00, oldW[15:8]};
      check(loadData == expLoad, idx[0] ? "R4" : "R3", "load byte",
            32'(loadData), 32'(expLoad));
      check(rdCnt == r0 + 1 && wrCnt == w0, "R7", "load access count",
            32'(wrCnt - w0), 32'd0);
    end else begin
      expW = idx[0] ? {oldW[15:8], dat[7:0]} : {dat[7:0], oldW[7:0]};
      shadow[ea[7:0]] = expW;
      check(mem[ea[7:0]] == expW, "R5", "stored word", 32'(mem[ea[7:0]]), 32'(expW));
      check(wrAddr == rdAddr && wrAt - rdAt == 2 && wrCnt == w0 + 1 && rdCnt == r0 + 1,
            "R7", "read then write spacing", 32'(wrAt - rdAt), 32'd2);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = patternOf(i);
    repeat (3) @(negedge clk);
    // R9 reset state
    check(ready == 1'b1 && done == 1'b0 && memRe == 1'b0 && memWe == 1'b0,
          "R9", "reset outputs", {28'd0, ready, done, memRe, memWe}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && done == 1'b0, "R9", "idle after reset",
          {30'd0, ready, done}, 32'h2);

    for (int v = 0; v < NVEC; v++)
      runOp(VEC[v][48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);

    // R6: upper datum bits ignored (vectors 7 and 12 already carry them)
    check(mem[8'h00][7:0] == 8'h77 && mem[8'h00][15:8] == patternOf(0) >> 8,
          "R6", "upper datum bits", 32'(mem[8'h00]), 32'({patternOf(0) >> 8, 8'h77}));

    // R2 / R1: large positive odd index
    runOp(1'b0, 16'h0100, 16'h00FF, 16'h0);

    // R8: requests while busy are ignored
    begin
      int w0, lat;
      logic [15:0] keep61;
      keep61 = shadow[8'h61];
      w0 = wrCnt;
      reqValid = 1'b1; reqOp = 1'b1; reqBase = 16'h0060; reqIndex = 16'h0000; reqData = 16'h0012;
      @(posedge clk);
      lat = 0;
      do begin
        @(negedge clk);
        lat++;
        if (lat == 1) begin
          reqBase = 16'h0061; reqData = 16'h0099;
          check(!ready, "R8", "ready while busy", 32'(ready), 32'd0);
        end
        if (lat == 3) reqValid = 1'b0;
      end while (!done && lat < 20);
      shadow[8'h60] = {8'h12, shadow[8'h60][7:0]};
      check(mem[8'h60] == shadow[8'h60], "R8", "accepted store", 32'(mem[8'h60]), 32'(shadow[8'h60]));
      check(mem[8'h61] == keep61 && wrCnt == w0 + 1, "R8", "busy request ignored",
            32'(mem[8'h61]), 32'(keep61));
      @(negedge clk);
      check(!done && ready && !memRe, "R8", "done single pulse, no new op",
            {29'd0, done, ready, memRe}, 32'h2);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule